// File: doc/BRIEF.md
# Two-Pass Layer Normalization Unit

This block normalizes one embedding vector of `D` signed fixed-point elements and then applies a learned per-dimension gain and offset. Elements arrive on a valid/ready stream. The unit stores the whole vector and sums it while it fills. It then derives the mean by multiplying with a precomputed reciprocal of `D`.

A second sweep over the stored copy collects the squared deviations from the mean, which gives the variance. A small epsilon is added to the variance, and the inverse square root is read from an elaboration-time table. Each element is then scaled by that value and by its own gain. Its own offset is added, and the result is clamped to the output word. Outputs leave in input order. Gains and offsets live in internal register arrays that a simple write port updates.

The controller is a five-state machine:

- `ST_FILL` accepts elements. After the `D`-th handshake it moves to `ST_MEAN`.
- `ST_MEAN` lasts one cycle and latches the mean. It then moves to `ST_VAR`.
- `ST_VAR` spends `D` cycles summing squares. After the last stored element it moves to `ST_LOOKUP`.
- `ST_LOOKUP` lasts one cycle and latches the table value. It then moves to `ST_EMIT`.
- `ST_EMIT` presents one output per handshake. After the `D`-th output handshake it returns to `ST_FILL`.

Top module: `layernorm_2pass`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0. Every gain holds 1.0, which is the integer 64 with 6 fraction bits, and every offset holds 0.
- R2: Exactly `D` elements are taken per vector, one on each cycle where `in_valid` and `in_ready` are both 1. `in_ready` stays 0 from the cycle after the `D`-th accepted element until the cycle after the `D`-th output handshake, and `out_valid` is never 1 while `in_ready` is 1.
- R3: The mean is floor(S·K / 2^16). Here S is the signed sum of the `D` inputs and K = round(2^16 / D).
- R4: The variance is floor(Q·K / 2^16). Here Q is the sum over all elements of (x − mean)².
- R5: The inverse square root is entry A of a 2^LA-entry table (LA = 8 by default). A = min(variance + 1, 2^LA − 1). Entry v holds the largest integer r with r²·v ≤ 2^16. A constant vector therefore reads entry 1, which is 256.
- R6: Output i is floor((x_i − mean)·r·g_i / 2^10) + b_i. Gain g_i is signed with 6 fraction bits. Offset b_i is a signed integer in output units. Outputs carry 4 fraction bits.
- R7: Any result above 127 is output as 127, and any result below −128 is output as −128. Results never wrap.
- R8: Outputs leave in the order the inputs arrived. `out_data` stays unchanged while `out_valid` is 1 and `out_ready` is 0.
- R9: A cycle with `wr_en` = 1 writes `wr_data` into gain `wr_idx` when `wr_sel` = 0, and into offset `wr_idx` when `wr_sel` = 1. The new value is used by every later vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input element present |
| in_ready | output | 1 | Unit accepts an element |
| in_data | input | DW | Signed input element |
| out_valid | output | 1 | Output element present |
| out_ready | input | 1 | Consumer accepts the output element |
| out_data | output | DW | Signed normalized element, 4 fraction bits |
| wr_en | input | 1 | Parameter write strobe |
| wr_sel | input | 1 | 0 selects the gain array, 1 selects the offset array |
| wr_idx | input | IW | Dimension being written |
| wr_data | input | DW | Signed gain or offset value |

## Verification
A corrupted running sum, mean or variance register skews every output of the vector. The error shows at the first output handshake, `D + 2` cycles after the last input is accepted. A wrong element index or a broken buffer write displaces single outputs or shuffles their order.

A state machine that leaves a state at the wrong count shows up as the wrong number of accepted inputs or delivered outputs. It can also show as `in_ready` and `out_valid` overlapping, which the bound checker flags in the cycle it happens. A clamp that wraps shows up as a sign flip on the first output pushed beyond the word range.

// File: rtl/lnorm_pkg.sv
package lnorm_pkg;

    // Fraction bits of the reciprocal of D used for both averages.
    localparam int RECIP_FB = 16;

    typedef enum logic [2:0] {
        ST_FILL,
        ST_MEAN,
        ST_VAR,
        ST_LOOKUP,
        ST_EMIT
    } ln_state_e;

endpackage

// File: rtl/lnorm_rsqrt_rom.sv
module lnorm_rsqrt_rom #(
    parameter int LA = 8,
    parameter int RB = 8
) (
    input  logic [LA-1:0] addr,
    output logic [RB:0]   val
);

    localparam int ENTRIES = 1 << LA;

    // Largest r with r*r*v <= 2^(2*RB); entry 0 is pinned to the top value.
    function automatic logic [RB:0] rsq(input int v);
        longint lim;
        int     r;
        lim = longint'(1) << (2 * RB);
        r   = 0;
        if (v == 0) begin
            r = 1 << RB;
        end else begin
            for (int k = 0; k <= (1 << RB); k++) begin
                if (longint'(k) * longint'(k) * longint'(v) <= lim) begin
                    r = k;
                end
            end
        end
        return (RB+1)'(r);
    endfunction

    logic [RB:0] tbl [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        localparam logic [RB:0] VAL = rsq(g);
        assign tbl[g] = VAL;
    end

    assign val = tbl[addr];

endmodule

// File: rtl/lnorm_affine_regs.sv
module lnorm_affine_regs #(
    parameter int D  = 64,
    parameter int DW = 8,
    parameter int GF = 6,
    localparam int IW = (D > 1) ? $clog2(D) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [IW-1:0]        wr_idx,
    input  logic signed [DW-1:0] wr_data,
    input  logic [IW-1:0]        rd_idx,
    output logic signed [DW-1:0] gain,
    output logic signed [DW-1:0] offs
);

    localparam logic signed [DW-1:0] UNITY = DW'(1 << GF);

    logic signed [DW-1:0] gain_q [D];
    logic signed [DW-1:0] offs_q [D];

    for (genvar i = 0; i < D; i++) begin : g_dim
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                gain_q[i] <= UNITY;
                offs_q[i] <= '0;
            end else if (wr_en && wr_idx == IW'(i)) begin
                if (wr_sel) begin
                    offs_q[i] <= wr_data;
                end else begin
                    gain_q[i] <= wr_data;
                end
            end
        end
    end

    assign gain = gain_q[rd_idx];
    assign offs = offs_q[rd_idx];

endmodule

// File: rtl/layernorm_2pass.sv
module layernorm_2pass
    import lnorm_pkg::*;
#(
    parameter int D   = 64,
    parameter int DW  = 8,
    parameter int GF  = 6,
    parameter int OF  = 4,
    parameter int RB  = 8,
    parameter int LA  = 8,
    parameter int EPS = 1,
    localparam int IW = (D > 1) ? $clog2(D) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic signed [DW-1:0] in_data,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic signed [DW-1:0] out_data,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [IW-1:0]        wr_idx,
    input  logic signed [DW-1:0] wr_data
);

    localparam int SW   = DW + IW + 1;
    localparam int XW   = DW + 2;
    localparam int SQW  = 2 * XW;
    localparam int QW   = SQW + IW;
    localparam int RECW = RECIP_FB + 1;
    localparam int MPW  = SW + RECW + 1;
    localparam int VPW  = QW + RECW;
    localparam int RW   = RB + 1;
    localparam int PW   = XW + RW + 1 + DW + 2;
    localparam int SH   = RB + GF - OF;
    localparam logic [RECW-1:0] RECIP = RECW'(((1 << RECIP_FB) + D / 2) / D);
    localparam logic [VPW-1:0]  ATOP  = VPW'((1 << LA) - 1);
    localparam logic signed [PW-1:0] YMAX = PW'((1 << (DW - 1)) - 1);
    localparam logic signed [PW-1:0] YMIN = -YMAX - PW'(1);

    ln_state_e st_q, st_d;

    logic [IW-1:0]        idx_q;
    logic signed [DW-1:0] buf_q [D];
    logic signed [SW-1:0] sum_q;
    logic [QW-1:0]        sq_q;
    logic signed [XW-1:0] mean_q;
    logic [RW-1:0]        rs_q;

    logic in_fire, out_fire, last;
    assign in_fire  = in_valid && in_ready;
    assign out_fire = out_valid && out_ready;
    assign last     = (idx_q == IW'(D - 1));

    // Shared datapath terms
    logic signed [MPW-1:0] mprod;
    logic signed [XW-1:0]  diff;
    logic signed [SQW-1:0] sqp;
    logic [VPW-1:0]        vprod, vare;
    logic [LA-1:0]         raddr;
    logic [RW-1:0]         rval;
    logic signed [DW-1:0]  gain, offs;
    logic signed [PW-1:0]  prod, ysum;

    assign mprod = MPW'(sum_q) * MPW'($signed({1'b0, RECIP}));
    assign diff  = XW'(buf_q[idx_q]) - mean_q;
    assign sqp   = SQW'(diff) * SQW'(diff);
    assign vprod = VPW'(sq_q) * VPW'(RECIP);
    assign vare  = (vprod >> RECIP_FB) + VPW'(EPS);
    assign raddr = (vare > ATOP) ? ATOP[LA-1:0] : vare[LA-1:0];
    assign prod  = PW'(diff) * PW'($signed({1'b0, rs_q})) * PW'(gain);
    assign ysum  = (prod >>> SH) + PW'(offs);

    lnorm_rsqrt_rom #(.LA(LA), .RB(RB)) u_rom (
        .addr (raddr),
        .val  (rval)
    );

    lnorm_affine_regs #(.D(D), .DW(DW), .GF(GF)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (idx_q),
        .gain    (gain),
        .offs    (offs)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_FILL;
        end else begin
            st_q <= st_d;
        end
    end

    // Transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_FILL:   if (in_fire && last) st_d = ST_MEAN;
            ST_MEAN:   st_d = ST_VAR;
            ST_VAR:    if (last) st_d = ST_LOOKUP;
            ST_LOOKUP: st_d = ST_EMIT;
            ST_EMIT:   if (out_fire && last) st_d = ST_FILL;
            default:   st_d = ST_FILL;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            sum_q  <= '0;
            sq_q   <= '0;
            mean_q <= '0;
            rs_q   <= '0;
        end else begin
            unique case (st_q)
                ST_FILL: if (in_fire) begin
                    buf_q[idx_q] <= in_data;
                    sum_q <= (idx_q == '0) ? SW'(in_data) : sum_q + SW'(in_data);
                    idx_q <= last ? '0 : idx_q + IW'(1);
                end
                ST_MEAN: mean_q <= XW'(mprod >>> RECIP_FB);
                ST_VAR: begin
                    sq_q  <= (idx_q == '0) ? QW'(sqp) : sq_q + QW'(sqp);
                    idx_q <= last ? '0 : idx_q + IW'(1);
                end
                ST_LOOKUP: rs_q <= rval;
                ST_EMIT: if (out_fire) idx_q <= last ? '0 : idx_q + IW'(1);
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        in_ready  = (st_q == ST_FILL);
        out_valid = (st_q == ST_EMIT);
        if (ysum > YMAX) begin
            out_data = YMAX[DW-1:0];
        end else if (ysum < YMIN) begin
            out_data = YMIN[DW-1:0];
        end else begin
            out_data = ysum[DW-1:0];
        end
    end

endmodule

// File: rtl/lnorm_checker.sv
module lnorm_checker #(
    parameter int D  = 64,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [DW-1:0] out_data
);

    localparam int CW = $clog2(D + 1);

    logic [CW-1:0] acc_cnt, out_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_cnt <= '0;
            out_cnt <= '0;
        end else begin
            if (in_valid && in_ready) acc_cnt <= acc_cnt + CW'(1);
            if (out_valid && out_ready) begin
                if (out_cnt == CW'(D - 1)) begin
                    out_cnt <= '0;
                    acc_cnt <= '0;
                end else begin
                    out_cnt <= out_cnt + CW'(1);
                end
            end
        end
    end

    a_r2_ready_low_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_cnt == CW'(D)) |-> !in_ready);

    a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid);

    a_r2_emit_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (acc_cnt == CW'(D)));

    a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

bind layernorm_2pass lnorm_checker #(.D(D), .DW(DW)) u_lnorm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/test_layernorm_2pass.sv
module test_layernorm_2pass;

    localparam int D  = 8;
    localparam int DW = 8;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic signed [DW-1:0] in_data = '0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic signed [DW-1:0] out_data;
    logic wr_en = 1'b0;
    logic wr_sel = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic signed [DW-1:0] wr_data = '0;

    int checks = 0;
    int errors = 0;
    int g_m [D];
    int b_m [D];

    always #5 clk = ~clk;

    layernorm_2pass #(.D(D), .DW(DW)) i_layernorm_2pass (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rsq_ref(input int v);
        int r = 0;
        while ((r + 1) * (r + 1) * v <= 65536) r++;
        return r;
    endfunction

    // Expected outputs from R3..R7
    function automatic void model(input int xs[D], output int ys[D]);
        int k, s, mean, q, vv, a, r, y;
        longint p;
        k = (65536 + D / 2) / D;
        s = 0;
        foreach (xs[i]) s += xs[i];
        mean = int'((longint'(s) * k) >>> 16);
        q = 0;
        foreach (xs[i]) q += (xs[i] - mean) * (xs[i] - mean);
        vv = int'((longint'(q) * k) >>> 16);
        a = vv + 1;
        if (a > 255) a = 255;
        r = rsq_ref(a);
        foreach (xs[i]) begin
            p = longint'(xs[i] - mean) * r * g_m[i];
            y = int'(p >>> 10) + b_m[i];
            if (y > 127) y = 127;
            if (y < -128) y = -128;
            ys[i] = y;
        end
    endfunction

    task automatic write_param(input bit sel, input int idx, input int val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_idx = IW'(idx); wr_data = DW'(val);
        @(negedge clk);
        wr_en = 1'b0;
        if (sel) b_m[idx] = val; else g_m[idx] = val;
    endtask

    // Send one vector, then collect and compare its D outputs.
    task automatic run_vec(input string tag, input int xs[D], input bit gaps, input bit stall);
        int ys[D];
        bit acc;
        logic signed [DW-1:0] held;
        model(xs, ys);
        for (int i = 0; i < D; i++) begin
            in_data = DW'(xs[i]);
            in_valid = 1'b1;
            forever begin
                acc = in_ready;
                @(negedge clk);
                if (acc) break;
            end
            if (gaps) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
        chk({tag, " R2 ready low after D inputs"}, int'(in_ready), 0);
        for (int i = 0; i < D; i++) begin
            out_ready = 1'b0;
            while (!out_valid) @(negedge clk);
            if (stall && (i % 2 == 0)) begin
                held = out_data;
                @(negedge clk);
                chk({tag, " R8 valid held on stall"}, int'(out_valid), 1);
                chk({tag, " R8 data held on stall"}, int'(out_data), int'(held));
            end
            chk($sformatf("%s R6 R7 R8 out[%0d]", tag, i), int'(out_data), ys[i]);
            chk({tag, " R2 ready low while emitting"}, int'(in_ready), 0);
            out_ready = 1'b1;
            @(negedge clk);
        end
        out_ready = 1'b0;
        chk({tag, " R2 ready back after last output"}, int'(in_ready), 1);
        chk({tag, " R2 no stray output"}, int'(out_valid), 0);
    endtask

    task automatic t_reset();
        chk("R1 in_ready after reset", int'(in_ready), 1);
        chk("R1 out_valid after reset", int'(out_valid), 0);
    endtask

    task automatic t_ramp();
        int xs[D] = '{-4, -3, -2, -1, 0, 1, 2, 3};
        run_vec("ramp R1 R3 R4", xs, 1'b0, 1'b0);
    endtask

    task automatic t_constant();
        int xs[D] = '{37, 37, 37, 37, 37, 37, 37, 37};
        int ys[D];
        run_vec("const R5 eps", xs, 1'b0, 1'b0);
        model(xs, ys);
        chk("R5 constant vector gives offset", ys[0], b_m[0]);
    endtask

    task automatic t_affine();
        int xs[D] = '{10, -20, 5, 0, 15, -7, 3, -1};
        for (int i = 0; i < D; i++) write_param(1'b0, i, 16 * i - 56);
        for (int i = 0; i < D; i++) write_param(1'b1, i, 3 * i - 10);
        run_vec("affine R9", xs, 1'b1, 1'b0);
    endtask

    task automatic t_saturate();
        int xs[D] = '{-9, 9, -9, 9, 0, 0, 9, -9};
        for (int i = 0; i < D; i++) write_param(1'b0, i, (i % 2) ? 127 : -128);
        for (int i = 0; i < D; i++) write_param(1'b1, i, (i < 4) ? 100 : -100);
        run_vec("sat R7", xs, 1'b0, 1'b0);
    endtask

    task automatic t_wide();
        int xs[D] = '{127, -128, 127, -128, 127, -128, 127, -128};
        for (int i = 0; i < D; i++) write_param(1'b0, i, 64);
        for (int i = 0; i < D; i++) write_param(1'b1, i, 0);
        run_vec("wide R5 clip", xs, 1'b0, 1'b0);
    endtask

    task automatic t_stall();
        int xs[D] = '{1, 50, -30, 7, -2, 90, -60, 11};
        run_vec("stall R8", xs, 1'b1, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < D; i++) begin
            g_m[i] = 64;
            b_m[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ramp();
        t_constant();
        t_affine();
        t_saturate();
        t_wide();
        t_stall();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule